// File: doc/BRIEF.md
# Prefix-Ordered Ternary CAM Updater

This block is a small ternary match table for longest-prefix lookup, with an update engine that adds new prefixes without disturbing the search order. Each slot stores a key value, a care mask and a next-hop tag. A lookup compares a key against every valid slot in parallel. It returns the tag of the lowest-addressed slot that matches. Slots are grouped by prefix length: the longest group sits at address zero and each shorter group follows it. Because of this layout, the lowest-addressed match is always the longest matching prefix.

To insert a prefix of length L, the engine works from the shortest group up to the group just below L. In every non-empty group it takes the entry at the front and copies it into the hole at the back. This moves the hole one group closer to the front of the table. After that it writes the new entry into the hole, which now sits at the tail of group L. Entries within a group may be in any order, so an insert costs at most one move per group instead of a shift of every entry below the insertion point. Per-length start and end pointers track each group. A delete clears the valid bit of the slot that a lookup of the same key would hit. That slot remains in its group as a dead hole.

All commands share one port. While an insert is moving entries the block reports busy and drops any command it is given.

Top module: `tcam_lpm_updater`

## Requirements
- R1: A slot matches a key when every bit where the care mask is 1 equals the stored value; bits with care 0 match either key value. A prefix of length L sets care on the top L key bits only.
- R2: Command codes on cmd_op are 2'b00 lookup, 2'b01 insert and 2'b10 delete. A lookup accepted at a clock edge drives res_valid high for exactly the following cycle, with res_hit=1 and res_tag holding the tag of the longest stored prefix that matches.
- R3: When no valid slot matches, the response has res_hit=0 and res_tag=0.
- R4: Every prefix stored before an insert is still found, with its own tag and precedence, after the insert completes.
- R5: An insert of length L that is accepted at a clock edge holds busy high from that edge onward. ins_done pulses high for one cycle, L+1 edges after the accepting edge, and busy is low in that same cycle.
- R6: Any command presented while busy is high is dropped. It gives no response, deletes nothing and stores nothing.
- R7: A delete invalidates the slot that a lookup of the same key would hit and responds like a lookup, reporting that slot's tag. The freed slot still counts toward capacity.
- R8: When all DEPTH slots are occupied, an insert is refused. ins_full_err pulses for one cycle after the accepting edge, busy stays low, and the table does not change.
- R9: An insert length above KEY_W is treated as KEY_W.
- R10: After reset, busy, res_valid, ins_done and ins_full_err are low and the table is empty, so every lookup misses.
- R11: Command code 2'b11 has no effect: it produces no response, no done pulse and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| cmd_key | input | KEY_W | Search key, or prefix value for an insert |
| cmd_len | input | $clog2(KEY_W+1) | Prefix length for an insert |
| cmd_tag | input | TAG_W | Next-hop tag for an insert |
| busy | output | 1 | Insert in progress; commands are dropped |
| res_valid | output | 1 | Lookup or delete response is present |
| res_hit | output | 1 | Response found a match |
| res_tag | output | TAG_W | Tag of the matched slot, 0 on a miss |
| ins_done | output | 1 | One-cycle pulse when an insert finishes |
| ins_full_err | output | 1 | One-cycle pulse when an insert is refused |

## Verification
Lookup and delete responses are registered at the edge that accepts the command. The bench drives each command on a falling edge and samples the response on the next falling edge, which is exactly one cycle later. For an insert of length L, the bench counts falling edges from the one where the command was driven and expects ins_done on the (L+2)-th. That count covers the accepting edge, L move steps and the write. A refused insert is checked on the first falling edge after acceptance for the error pulse and low busy, and on the next one for the pulse to have cleared. Commands dropped during busy are checked on the falling edge where their response would otherwise appear. The table state they could have changed is then read back through later lookups.

// File: rtl/tcam_lpm_pkg.sv
package tcam_lpm_pkg;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'b00,
        OP_INSERT = 2'b01,
        OP_DELETE = 2'b10,
        OP_NONE   = 2'b11
    } tcam_op_e;

    typedef enum logic [1:0] {
        UPD_IDLE  = 2'b00,
        UPD_STEP  = 2'b01,
        UPD_WRITE = 2'b10
    } upd_state_e;

    // bits needed for a pointer that ranges over 0..depth inclusive
    function automatic int unsigned ptr_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    // stored entry width: valid + value + care + tag
    function automatic int unsigned entry_width(input int unsigned key_w,
                                                input int unsigned tag_w);
        return 1 + 2 * key_w + tag_w;
    endfunction

endpackage

// File: rtl/tcam_prio.sv
module tcam_prio #(
    parameter int N  = 32,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [AW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = AW'(i);
            end
        end
    end

    // the encoder reports a set bit with nothing set below it
    always_comb begin
        if (any) begin
            AST_PRIO_LOWEST: assert (vec[idx] && ((vec & ((N'(1) << idx) - N'(1))) == '0)); // R2
        end else begin
            AST_PRIO_NONE: assert (vec == '0); // R3
        end
    end

endmodule

// File: rtl/tcam_store.sv
module tcam_store
    import tcam_lpm_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int DEPTH = 32,
    parameter int TAG_W = 4,
    parameter int AW    = $clog2(DEPTH),
    parameter int ENT_W = entry_width(KEY_W, TAG_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [ENT_W-1:0]  wr_data,
    input  logic              clr_en,
    input  logic [AW-1:0]     clr_addr,
    input  logic [AW-1:0]     rd_addr,
    output logic [ENT_W-1:0]  rd_data,
    input  logic [KEY_W-1:0]  srch_key,
    output logic [DEPTH-1:0]  hit_vec,
    input  logic [AW-1:0]     tag_addr,
    output logic [TAG_W-1:0]  tag_out
);

    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] val;
        logic [KEY_W-1:0] care;
        logic [TAG_W-1:0] tag;
    } slot_t;

    slot_t slots_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
        end else begin
            if (wr_en) slots_q[wr_addr] <= slot_t'(wr_data);
            if (clr_en) slots_q[clr_addr].valid <= 1'b0;
        end
    end

    assign rd_data = slots_q[rd_addr];
    assign tag_out = slots_q[tag_addr].tag;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign hit_vec[g] = slots_q[g].valid &&
                            (((srch_key ^ slots_q[g].val) & slots_q[g].care) == '0);
    end

    // a delete can never coincide with a relocation or insert write
    AST_WR_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && clr_en)); // R6

endmodule

// File: rtl/tcam_upd_ctrl.sv
module tcam_upd_ctrl
    import tcam_lpm_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int DEPTH = 32,
    parameter int TAG_W = 4,
    parameter int AW    = $clog2(DEPTH),
    parameter int LEN_W = $clog2(KEY_W + 1),
    parameter int ENT_W = entry_width(KEY_W, TAG_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_req,
    input  logic [KEY_W-1:0]  ins_key,
    input  logic [LEN_W-1:0]  ins_len,
    input  logic [TAG_W-1:0]  ins_tag,
    output logic              busy,
    output logic              done,
    output logic              full_err,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic              wr_move,
    output logic [AW-1:0]     wr_addr,
    output logic [ENT_W-1:0]  new_ent
);

    localparam int PW = ptr_width(DEPTH);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(KEY_W);

    typedef struct packed {
        logic             valid;
        logic [KEY_W-1:0] val;
        logic [KEY_W-1:0] care;
        logic [TAG_W-1:0] tag;
    } slot_t;

    upd_state_e       st_q;
    logic [LEN_W-1:0] cur_q;
    logic [LEN_W-1:0] tgt_q;
    slot_t            new_q;
    logic             done_q;
    logic             err_q;
    // group for length L occupies [start_q[L], end_q[L])
    logic [PW-1:0]    start_q [KEY_W+1];
    logic [PW-1:0]    end_q   [KEY_W+1];

    logic [LEN_W-1:0] len_sat;
    logic [KEY_W-1:0] len_mask;
    logic             table_full;
    logic             grp_nonempty;

    assign len_sat    = (ins_len > MAX_LEN) ? MAX_LEN : ins_len;
    assign len_mask   = ~({KEY_W{1'b1}} >> len_sat);
    assign table_full = (end_q[0] == PW'(DEPTH));
    assign grp_nonempty = (start_q[cur_q] != end_q[cur_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= UPD_IDLE;
            cur_q  <= '0;
            tgt_q  <= '0;
            new_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            for (int l = 0; l <= KEY_W; l++) begin
                start_q[l] <= '0;
                end_q[l]   <= '0;
            end
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (st_q)
                UPD_IDLE: begin
                    if (ins_req) begin
                        if (table_full) begin
                            err_q <= 1'b1;
                        end else begin
                            tgt_q      <= len_sat;
                            cur_q      <= '0;
                            new_q.valid <= 1'b1;
                            new_q.val  <= ins_key & len_mask;
                            new_q.care <= len_mask;
                            new_q.tag  <= ins_tag;
                            st_q       <= (len_sat == '0) ? UPD_WRITE : UPD_STEP;
                        end
                    end
                end
                UPD_STEP: begin
                    // the group slides one slot toward the free space
                    start_q[cur_q] <= start_q[cur_q] + PW'(1);
                    end_q[cur_q]   <= end_q[cur_q] + PW'(1);
                    if (cur_q == tgt_q - LEN_W'(1)) st_q <= UPD_WRITE;
                    else                            cur_q <= cur_q + LEN_W'(1);
                end
                UPD_WRITE: begin
                    end_q[tgt_q] <= end_q[tgt_q] + PW'(1);
                    done_q       <= 1'b1;
                    st_q         <= UPD_IDLE;
                end
                default: st_q <= UPD_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != UPD_IDLE);
    assign done     = done_q;
    assign full_err = err_q;
    assign rd_addr  = start_q[cur_q][AW-1:0];
    assign wr_move  = (st_q == UPD_STEP);
    assign wr_en    = (wr_move && grp_nonempty) || (st_q == UPD_WRITE);
    assign wr_addr  = (st_q == UPD_WRITE) ? end_q[tgt_q][AW-1:0]
                                          : end_q[cur_q][AW-1:0];
    assign new_ent  = new_q;

    // adjacent groups abut whenever no insert is in flight
    for (genvar g = 1; g <= KEY_W; g++) begin : g_chain
        AST_GROUP_CHAIN: assert property (@(posedge clk) disable iff (rst)
            (st_q == UPD_IDLE) |-> (end_q[g] == start_q[g-1])); // R4
    end

    AST_LONGEST_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        start_q[KEY_W] == '0); // R4

    AST_STEP_BELOW_TARGET: assert property (@(posedge clk) disable iff (rst)
        (st_q == UPD_STEP) |-> (cur_q < tgt_q)); // R5

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (st_q == UPD_IDLE) && $past(st_q == UPD_WRITE)); // R5

    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (rst)
        end_q[0] <= PW'(DEPTH)); // R8

    AST_FULL_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (st_q == UPD_IDLE) && $stable(end_q[0]) && (end_q[0] == PW'(DEPTH))); // R8

endmodule

// File: rtl/tcam_lpm_updater.sv
module tcam_lpm_updater
    import tcam_lpm_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int DEPTH = 32,
    parameter int TAG_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [KEY_W-1:0]           cmd_key,
    input  logic [$clog2(KEY_W+1)-1:0] cmd_len,
    input  logic [TAG_W-1:0]           cmd_tag,
    output logic                       busy,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic [TAG_W-1:0]           res_tag,
    output logic                       ins_done,
    output logic                       ins_full_err
);

    localparam int AW    = $clog2(DEPTH);
    localparam int LEN_W = $clog2(KEY_W + 1);
    localparam int ENT_W = entry_width(KEY_W, TAG_W);

    tcam_op_e         op;
    logic             accept;
    logic             ins_req;
    logic             srch_req;
    logic [DEPTH-1:0] hit_vec;
    logic             hit_any;
    logic [AW-1:0]    hit_idx;
    logic [TAG_W-1:0] hit_tag;
    logic [AW-1:0]    rd_addr;
    logic [ENT_W-1:0] rd_data;
    logic             wr_en;
    logic             wr_move;
    logic [AW-1:0]    wr_addr;
    logic [ENT_W-1:0] new_ent;
    logic [ENT_W-1:0] wr_data;
    logic             clr_en;
    logic             busy_w;

    logic             res_valid_q;
    logic             res_hit_q;
    logic [TAG_W-1:0] res_tag_q;

    assign op       = tcam_op_e'(cmd_op);
    assign accept   = cmd_valid && !busy_w;
    assign ins_req  = accept && (op == OP_INSERT);
    assign srch_req = accept && ((op == OP_LOOKUP) || (op == OP_DELETE));
    assign clr_en   = accept && (op == OP_DELETE) && hit_any;
    assign wr_data  = wr_move ? rd_data : new_ent;

    tcam_store #(
        .KEY_W (KEY_W),
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clr_en   (clr_en),
        .clr_addr (hit_idx),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .srch_key (cmd_key),
        .hit_vec  (hit_vec),
        .tag_addr (hit_idx),
        .tag_out  (hit_tag)
    );

    tcam_prio #(
        .N (DEPTH)
    ) u_prio (
        .vec (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    tcam_upd_ctrl #(
        .KEY_W (KEY_W),
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ins_req  (ins_req),
        .ins_key  (cmd_key),
        .ins_len  (cmd_len),
        .ins_tag  (cmd_tag),
        .busy     (busy_w),
        .done     (ins_done),
        .full_err (ins_full_err),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_move  (wr_move),
        .wr_addr  (wr_addr),
        .new_ent  (new_ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_q <= 1'b0;
            res_hit_q   <= 1'b0;
            res_tag_q   <= '0;
        end else begin
            res_valid_q <= srch_req;
            res_hit_q   <= srch_req && hit_any;
            res_tag_q   <= (srch_req && hit_any) ? hit_tag : '0;
        end
    end

    assign busy      = busy_w;
    assign res_valid = res_valid_q;
    assign res_hit   = res_hit_q;
    assign res_tag   = res_tag_q;

    AST_RESP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        res_valid_q |-> $past(cmd_valid && !busy_w)); // R6

    AST_MISS_TAG_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid_q && !res_hit_q) |-> (res_tag_q == '0)); // R3

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ins_done && ins_full_err)); // R8

    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        ins_full_err |-> !busy_w); // R8

endmodule

// File: tb/tb_tcam_lpm_updater.sv
module tb_tcam_lpm_updater;

    localparam int CLK_PERIOD = 10;
    localparam int KEY_W = 8;
    localparam int DEPTH = 32;
    localparam int TAG_W = 4;
    localparam int LEN_W = $clog2(KEY_W + 1);
    localparam int NV    = 18;

    // {op, key, len, tag, exp_hit, exp_tag}; op 0 lookup, 1 insert, 2 delete
    localparam logic [22:0] VEC [NV] = '{
        {2'd1, 8'hA0, 4'd4, 4'd1, 1'b0, 4'd0},
        {2'd1, 8'hA8, 4'd5, 4'd2, 1'b0, 4'd0},
        {2'd1, 8'h00, 4'd0, 4'd3, 1'b0, 4'd0},
        {2'd1, 8'hAB, 4'd8, 4'd4, 1'b0, 4'd0},
        {2'd0, 8'hAB, 4'd0, 4'd0, 1'b1, 4'd4},
        {2'd0, 8'hAC, 4'd0, 4'd0, 1'b1, 4'd2},
        {2'd0, 8'hA4, 4'd0, 4'd0, 1'b1, 4'd1},
        {2'd0, 8'h55, 4'd0, 4'd0, 1'b1, 4'd3},
        {2'd2, 8'hAC, 4'd0, 4'd0, 1'b1, 4'd2},
        {2'd0, 8'hAC, 4'd0, 4'd0, 1'b1, 4'd1},
        {2'd2, 8'h55, 4'd0, 4'd0, 1'b1, 4'd3},
        {2'd0, 8'h55, 4'd0, 4'd0, 1'b0, 4'd0},
        {2'd1, 8'h40, 4'd2, 4'd5, 1'b0, 4'd0},
        {2'd0, 8'h55, 4'd0, 4'd0, 1'b1, 4'd5},
        {2'd0, 8'hC0, 4'd0, 4'd0, 1'b0, 4'd0},
        {2'd1, 8'hFF, 4'd1, 4'd6, 1'b0, 4'd0},
        {2'd0, 8'hC0, 4'd0, 4'd0, 1'b1, 4'd6},
        {2'd0, 8'h3F, 4'd0, 4'd0, 1'b0, 4'd0}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_valid;
    logic [1:0]       cmd_op;
    logic [KEY_W-1:0] cmd_key;
    logic [LEN_W-1:0] cmd_len;
    logic [TAG_W-1:0] cmd_tag;
    logic             busy;
    logic             res_valid;
    logic             res_hit;
    logic [TAG_W-1:0] res_tag;
    logic             ins_done;
    logic             ins_full_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tcam_lpm_updater #(
        .KEY_W (KEY_W),
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_key      (cmd_key),
        .cmd_len      (cmd_len),
        .cmd_tag      (cmd_tag),
        .busy         (busy),
        .res_valid    (res_valid),
        .res_hit      (res_hit),
        .res_tag      (res_tag),
        .ins_done     (ins_done),
        .ins_full_err (ins_full_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive on a falling edge, release on the next one; outputs then show the accepting edge
    task automatic apply(input logic [1:0] op, input logic [KEY_W-1:0] key,
                         input logic [LEN_W-1:0] len, input logic [TAG_W-1:0] tag);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_key   = key;
        cmd_len   = len;
        cmd_tag   = tag;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!ins_done && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic lookup_chk(input logic [KEY_W-1:0] key, input bit ehit,
                              input int etag, input string req);
        apply(2'd0, key, '0, '0);
        chk(res_valid == 1'b1, req, int'(res_valid), 1);
        chk(res_hit == ehit, req, int'(res_hit), int'(ehit));
        chk(int'(res_tag) == etag, req, int'(res_tag), etag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        rst = 1'b1;
        cmd_valid = 1'b0;
        cmd_op = '0;
        cmd_key = '0;
        cmd_len = '0;
        cmd_tag = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state, empty table
        chk(!busy, "R10", int'(busy), 0);
        chk(!res_valid, "R10", int'(res_valid), 0);
        chk(!ins_done && !ins_full_err, "R10", int'(ins_done | ins_full_err), 0);
        lookup_chk(8'hAB, 1'b0, 0, "R10");

        // vector table: R2 hits, R3 misses, R5 insert timing, R7 deletes
        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            apply(v[22:21], v[20:13], v[12:9], v[8:5]);
            if (v[22:21] == 2'd1) begin
                chk(busy == 1'b1, "R5", int'(busy), 1);
                wait_done(cyc);
                chk(cyc == int'(v[12:9]) + 2, "R5", cyc, int'(v[12:9]) + 2);
                chk(!busy, "R5", int'(busy), 0);
            end else begin
                chk(res_valid == 1'b1, "R2", int'(res_valid), 1);
                chk(res_hit == v[4], v[4] ? "R2" : "R3", int'(res_hit), int'(v[4]));
                chk(res_tag == v[3:0], v[22:21] == 2'd2 ? "R7" : "R2",
                    int'(res_tag), int'(v[3:0]));
            end
        end

        // R1: wildcard tail bits accept either value
        lookup_chk(8'hAF, 1'b1, 1, "R1");

        // R6: commands during an insert are dropped (R9: length 15 saturates to 8)
        apply(2'd1, 8'h12, 4'd15, 4'd7);
        chk(busy == 1'b1, "R6", int'(busy), 1);
        apply(2'd0, 8'hAB, '0, '0);
        chk(!res_valid, "R6", int'(res_valid), 0);
        apply(2'd2, 8'hAB, '0, '0);
        chk(!res_valid, "R6", int'(res_valid), 0);
        apply(2'd1, 8'h77, 4'd8, 4'd9);
        chk(!ins_done && !ins_full_err, "R6", int'(ins_done | ins_full_err), 0);
        wait_done(cyc);
        chk(ins_done == 1'b1, "R9", int'(ins_done), 1);
        lookup_chk(8'hAB, 1'b1, 4, "R6");
        lookup_chk(8'h77, 1'b1, 5, "R6");
        lookup_chk(8'h12, 1'b1, 7, "R9");
        lookup_chk(8'h13, 1'b0, 0, "R9");

        // R11: reserved code does nothing
        apply(2'd3, 8'hAB, 4'd3, 4'd3);
        chk(!res_valid && !ins_done && !ins_full_err && !busy, "R11",
            int'(res_valid | ins_done | ins_full_err | busy), 0);

        // fill the remaining 25 slots with full-length prefixes
        for (int k = 0; k < 25; k++) begin
            apply(2'd1, 8'h80 + KEY_W'(k), 4'd8, TAG_W'(k));
            wait_done(cyc);
            chk(cyc == 10, "R5", cyc, 10);
        end

        // R4: earlier prefixes keep their precedence after many inserts
        lookup_chk(8'hAB, 1'b1, 4, "R4");
        lookup_chk(8'hA4, 1'b1, 1, "R4");
        lookup_chk(8'h85, 1'b1, 5, "R4");
        lookup_chk(8'h98, 1'b1, 8, "R4");
        lookup_chk(8'h99, 1'b1, 6, "R4");

        // R8: refused insert when full
        apply(2'd1, 8'h33, 4'd8, 4'd9);
        chk(ins_full_err == 1'b1, "R8", int'(ins_full_err), 1);
        chk(!busy, "R8", int'(busy), 0);
        @(negedge clk);
        chk(!ins_full_err && !ins_done, "R8", int'(ins_full_err | ins_done), 0);
        lookup_chk(8'h33, 1'b0, 0, "R8");

        // R7: a deleted slot still occupies capacity
        apply(2'd2, 8'h85, '0, '0);
        chk(res_valid && res_hit && res_tag == 4'd5, "R7", int'(res_tag), 5);
        lookup_chk(8'h85, 1'b1, 6, "R7");
        apply(2'd1, 8'h34, 4'd8, 4'd2);
        chk(ins_full_err == 1'b1, "R7", int'(ins_full_err), 1);
        @(negedge clk);
        lookup_chk(8'h34, 1'b0, 0, "R7");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule